// File: doc/BRIEF.md
# Out-of-Order Issue Window

This block is a small holding buffer that sits between instruction decode and the execution units. Decode writes up to two decoded operations per cycle into free slots. Each slot records four things: the functional unit the operation needs, one destination tag, two source tags, and a ready flag for each source. A slot stays in the buffer until its operands are available and its unit can take it.

Every cycle the block looks at each functional unit separately. There is one arithmetic unit and one load/store unit. For each unit, it offers the oldest slot that targets that unit and has both sources ready. Arrival order decides which slot is older, not slot position. A younger operation that is independent can therefore issue ahead of an older one that is still waiting for a result.

A completion port broadcasts the tags of finished results. Each broadcast marks the matching sources as ready. Decode is held off only when the buffer cannot take a full pair.

Top module: `issue_window`

## Requirements
- R1: After reset the buffer holds no entries, `dec_ready_o` is 1 and both issue valids are 0.
- R2: `dec_ready_o` is 1 exactly when at least two of the DEPTH slots are free. While it is 0, decode valids add no entry.
- R3: When `dec_ready_o` is 1, each set bit of `dec_valid_i` adds one entry, so up to two are added per cycle. Lane 0 counts as older than lane 1.
- R4: Issue port f (0 = arithmetic, 1 = load/store) offers only an entry whose unit code equals f and whose two source ready flags are both set.
- R5: Among the eligible entries for a unit, the port offers the earliest accepted one. It drives that entry's destination and source tags.
- R6: An eligible younger entry issues while an older entry for the same unit is still waiting.
- R7: A completion with `cpl_valid_i` high sets every held source flag whose tag equals `cpl_tag_i`. The affected entry can issue from the next cycle, not in the broadcast cycle.
- R8: An entry accepted in the same cycle as a completion whose tag matches one of its sources enters with that source ready.
- R9: Port f is valid only while `fu_free_i[f]` is 1. A held entry stays in the buffer. An entry offered on a valid port leaves the buffer at that clock edge and is issued once.
- R10: The buffer holds DEPTH = 12 entries. Six pairs fill it, and `dec_ready_o` then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 2 | Per-lane insert request |
| dec_ready_o | output | 1 | Two or more slots free |
| dec_fu_i | input | 2 | Per-lane unit code |
| dec_dst_i | input | 2*TAG_W | Per-lane destination tag |
| dec_src0_i | input | 2*TAG_W | Per-lane first source tag |
| dec_src1_i | input | 2*TAG_W | Per-lane second source tag |
| dec_rdy0_i | input | 2 | Per-lane first source already ready |
| dec_rdy1_i | input | 2 | Per-lane second source already ready |
| fu_free_i | input | 2 | Unit can accept an operation |
| iss_valid_o | output | 2 | Issue offered per unit |
| iss_dst_o | output | 2*TAG_W | Issued destination tag per unit |
| iss_src0_o | output | 2*TAG_W | Issued first source tag per unit |
| iss_src1_o | output | 2*TAG_W | Issued second source tag per unit |
| cpl_valid_i | input | 1 | Completion broadcast valid |
| cpl_tag_i | input | TAG_W | Completed destination tag |

## Verification
The bench builds the block with its default parameters, DEPTH = 12 and TAG_W = 6.

- **Full buffer.** With 12 slots, six directed pairs fill the buffer. This makes the pair-granular back-pressure point reachable in a few cycles, along with ignored inserts while full.
- **Waking waiting entries.** Random source and completion tags are drawn from only 16 values, far fewer than the 64 a 6-bit tag allows. Completions therefore wake waiting entries often.
- **Age selection.** Several eligible entries frequently compete for the same unit. This exercises age selection across slots that are filled and freed out of order.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int NUM_FU = 2;
  localparam int FU_W   = 1;
  localparam logic [FU_W-1:0] FU_ALU = 1'b0;
  localparam logic [FU_W-1:0] FU_LSU = 1'b1;
  localparam int LANES  = 2;
endpackage

// File: rtl/iw_alloc.sv
module iw_alloc #(
  parameter int DEPTH = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] vld_i,
  output logic [IDX_W-1:0] idx_a_o,
  output logic [IDX_W-1:0] idx_b_o,
  output logic             two_free_o
);
  logic found_a, found_b;

  always_comb begin
    idx_a_o = '0;
    idx_b_o = '0;
    found_a = 1'b0;
    found_b = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_i[i]) begin
        if (!found_a) begin
          idx_a_o = IDX_W'(i);
          found_a = 1'b1;
        end else if (!found_b) begin
          idx_b_o = IDX_W'(i);
          found_b = 1'b1;
        end
      end
    end
    two_free_o = found_b;
  end
endmodule

// File: rtl/iw_age.sv
module iw_age #(
  parameter int DEPTH = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  ins_i,
  input  logic [IDX_W-1:0]            idx_a_i,
  input  logic [IDX_W-1:0]            idx_b_i,
  output logic [DEPTH-1:0][DEPTH-1:0] old_o   // old_o[j][i]: j arrived before i
);
  logic [DEPTH-1:0][DEPTH-1:0] old_q, old_d;

  // newcomer: everyone is older than it, it is older than nobody;
  // lane 1 applied last so lane 0 ends up older
  always_comb begin
    old_d = old_q;
    if (ins_i[0]) begin
      for (int j = 0; j < DEPTH; j++) old_d[j][idx_a_i] = 1'b1;
      for (int j = 0; j < DEPTH; j++) old_d[idx_a_i][j] = 1'b0;
    end
    if (ins_i[1]) begin
      for (int j = 0; j < DEPTH; j++) old_d[idx_b_i][j] = 1'b0;
      for (int j = 0; j < DEPTH; j++) old_d[j][idx_b_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) old_q <= '0;
    else         old_q <= old_d;
  end

  assign old_o = old_q;
endmodule

// File: rtl/iw_select.sv
module iw_select #(
  parameter int DEPTH = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            elig_i,
  input  logic [DEPTH-1:0][DEPTH-1:0] old_i,
  output logic [DEPTH-1:0]            gnt_o,
  output logic                        any_o,
  output logic [IDX_W-1:0]            idx_o
);
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j != i && elig_i[j] && old_i[j][i]) blk = 1'b1;
      gnt_o[i] = elig_i[i] && !blk;
    end
    any_o = |elig_i;
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (gnt_o[i]) idx_o = idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/issue_window.sv
module issue_window
  import iw_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int TAG_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANES-1:0]          dec_valid_i,
  output logic                      dec_ready_o,
  input  logic [LANES*FU_W-1:0]     dec_fu_i,
  input  logic [LANES*TAG_W-1:0]    dec_dst_i,
  input  logic [LANES*TAG_W-1:0]    dec_src0_i,
  input  logic [LANES*TAG_W-1:0]    dec_src1_i,
  input  logic [LANES-1:0]          dec_rdy0_i,
  input  logic [LANES-1:0]          dec_rdy1_i,
  input  logic [NUM_FU-1:0]         fu_free_i,
  output logic [NUM_FU-1:0]         iss_valid_o,
  output logic [NUM_FU*TAG_W-1:0]   iss_dst_o,
  output logic [NUM_FU*TAG_W-1:0]   iss_src0_o,
  output logic [NUM_FU*TAG_W-1:0]   iss_src1_o,
  input  logic                      cpl_valid_i,
  input  logic [TAG_W-1:0]          cpl_tag_i
);
  localparam int IDX_W = $clog2(DEPTH);

  typedef struct packed {
    logic             r1;
    logic             r0;
    logic [TAG_W-1:0] s1;
    logic [TAG_W-1:0] s0;
    logic [TAG_W-1:0] dst;
    logic [FU_W-1:0]  fu;
  } ent_t;

  logic                        vld_q [DEPTH];
  ent_t                        ent_q [DEPTH];
  logic [DEPTH-1:0]            vld_vec;
  logic [IDX_W-1:0]            slot_a, slot_b;
  logic                        two_free;
  logic [LANES-1:0]            ins_en;
  ent_t                        new_ent [LANES];
  logic [DEPTH-1:0][DEPTH-1:0] old_m;
  logic [DEPTH-1:0]            elig  [NUM_FU];
  logic [DEPTH-1:0]            gnt   [NUM_FU];
  logic [NUM_FU-1:0]           any;
  logic [NUM_FU*IDX_W-1:0]     sel_idx;
  logic [DEPTH-1:0]            iss_clr;

  always_comb
    for (int i = 0; i < DEPTH; i++) vld_vec[i] = vld_q[i];

  iw_alloc #(.DEPTH(DEPTH)) u_alloc (
    .vld_i      (vld_vec),
    .idx_a_o    (slot_a),
    .idx_b_o    (slot_b),
    .two_free_o (two_free)
  );

  assign dec_ready_o = two_free;
  assign ins_en      = dec_valid_i & {LANES{two_free}};

  iw_age #(.DEPTH(DEPTH)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ins_i   (ins_en),
    .idx_a_i (slot_a),
    .idx_b_i (slot_b),
    .old_o   (old_m)
  );

  // incoming entries, with same-cycle completion wake-up
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      new_ent[k].fu  = dec_fu_i[k*FU_W +: FU_W];
      new_ent[k].dst = dec_dst_i[k*TAG_W +: TAG_W];
      new_ent[k].s0  = dec_src0_i[k*TAG_W +: TAG_W];
      new_ent[k].s1  = dec_src1_i[k*TAG_W +: TAG_W];
      new_ent[k].r0  = dec_rdy0_i[k] ||
                       (cpl_valid_i && cpl_tag_i == dec_src0_i[k*TAG_W +: TAG_W]);
      new_ent[k].r1  = dec_rdy1_i[k] ||
                       (cpl_valid_i && cpl_tag_i == dec_src1_i[k*TAG_W +: TAG_W]);
    end
  end

  // per-unit oldest-ready pick
  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    always_comb
      for (int i = 0; i < DEPTH; i++)
        elig[f][i] = vld_q[i] && ent_q[i].fu == FU_W'(f) && ent_q[i].r0 && ent_q[i].r1;

    iw_select #(.DEPTH(DEPTH)) u_sel (
      .elig_i (elig[f]),
      .old_i  (old_m),
      .gnt_o  (gnt[f]),
      .any_o  (any[f]),
      .idx_o  (sel_idx[f*IDX_W +: IDX_W])
    );

    assign iss_valid_o[f] = any[f] && fu_free_i[f];
    assign iss_dst_o[f*TAG_W +: TAG_W]  = ent_q[sel_idx[f*IDX_W +: IDX_W]].dst;
    assign iss_src0_o[f*TAG_W +: TAG_W] = ent_q[sel_idx[f*IDX_W +: IDX_W]].s0;
    assign iss_src1_o[f*TAG_W +: TAG_W] = ent_q[sel_idx[f*IDX_W +: IDX_W]].s1;
  end

  always_comb begin
    iss_clr = '0;
    for (int f = 0; f < NUM_FU; f++)
      if (iss_valid_o[f]) iss_clr = iss_clr | gnt[f];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        ent_q[i] <= '0;
      end else if (iss_clr[i]) begin
        vld_q[i] <= 1'b0;
      end else if (ins_en[0] && slot_a == IDX_W'(i)) begin
        vld_q[i] <= 1'b1;
        ent_q[i] <= new_ent[0];
      end else if (ins_en[1] && slot_b == IDX_W'(i)) begin
        vld_q[i] <= 1'b1;
        ent_q[i] <= new_ent[1];
      end else if (vld_q[i] && cpl_valid_i) begin
        if (ent_q[i].s0 == cpl_tag_i) ent_q[i].r0 <= 1'b1;
        if (ent_q[i].s1 == cpl_tag_i) ent_q[i].r1 <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/iw_chk.sv
module iw_chk #(
  parameter int DEPTH = 12,
  parameter int NFU   = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [DEPTH-1:0]      vld_i,
  input logic                  dec_ready_i,
  input logic [NFU-1:0]        iss_valid_i,
  input logic [NFU*IDX_W-1:0]  sel_idx_i
);
  AST_NO_GROW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_ready_i |=> $countones(vld_i) <= $past($countones(vld_i))) else $error("AST_NO_GROW_FULL"); // R2

  AST_GROW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_ready_i |=> $countones(vld_i) <= $past($countones(vld_i)) + 2) else $error("AST_GROW_BOUND"); // R3

  AST_NO_DUP_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&iss_valid_i) |-> sel_idx_i[0 +: IDX_W] != sel_idx_i[IDX_W +: IDX_W]) else $error("AST_NO_DUP_ISSUE"); // R4

  for (genvar f = 0; f < NFU; f++) begin : g_f
    AST_ISS_FROM_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_i[f] |-> vld_i[sel_idx_i[f*IDX_W +: IDX_W]]) else $error("AST_ISS_FROM_VALID"); // R4

    AST_ISSUED_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_i[f] |=> !vld_i[$past(sel_idx_i[f*IDX_W +: IDX_W])]) else $error("AST_ISSUED_LEAVES"); // R9
  end
endmodule

bind issue_window iw_chk #(.DEPTH(DEPTH), .NFU(iw_pkg::NUM_FU)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vld_i       (vld_vec),
  .dec_ready_i (dec_ready_o),
  .iss_valid_i (iss_valid_o),
  .sel_idx_i   (sel_idx)
);

// File: tb/sim_issue_window.sv
`timescale 1ns/1ps
module sim_issue_window;
  localparam int DEPTH = 12;
  localparam int TAG_W = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        dv = '0, dfu = '0, dr0 = '0, dr1 = '0, free = 2'b11;
  logic [2*TAG_W-1:0] ddst = '0, ds0 = '0, ds1 = '0;
  logic              cv = 1'b0;
  logic [TAG_W-1:0]  ctag = '0;
  logic              dec_ready_o;
  logic [1:0]        iss_valid_o;
  logic [2*TAG_W-1:0] iss_dst_o, iss_src0_o, iss_src1_o;

  int n_chk = 0, n_fail = 0, seq_n = 0;
  bit done = 0;

  bit m_v [DEPTH];
  int m_fu [DEPTH], m_dst [DEPTH], m_s0 [DEPTH], m_s1 [DEPTH], m_seq [DEPTH];
  bit m_r0 [DEPTH], m_r1 [DEPTH];

  always #10 clk_i = ~clk_i;

  issue_window #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
    .clk_i, .rst_ni,
    .dec_valid_i(dv), .dec_ready_o, .dec_fu_i(dfu),
    .dec_dst_i(ddst), .dec_src0_i(ds0), .dec_src1_i(ds1),
    .dec_rdy0_i(dr0), .dec_rdy1_i(dr1),
    .fu_free_i(free), .iss_valid_o, .iss_dst_o, .iss_src0_o, .iss_src1_o,
    .cpl_valid_i(cv), .cpl_tag_i(ctag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) c += int'(m_v[i]);
    return c;
  endfunction

  function automatic int m_pick(input int f);
    int b = -1;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_fu[i] == f && m_r0[i] && m_r1[i] && (b < 0 || m_seq[i] < m_seq[b])) b = i;
    return b;
  endfunction

  function automatic int dst_of(input int f);
    return int'(iss_dst_o[f*TAG_W +: TAG_W]);
  endfunction

  task automatic idle();
    dv = '0; cv = 1'b0;
  endtask

  task automatic set_lane(input int k, input int fu, input int dst, input int s0, input bit r0,
                          input int s1, input bit r1);
    dfu[k] = fu[0];
    ddst[k*TAG_W +: TAG_W] = TAG_W'(dst);
    ds0[k*TAG_W +: TAG_W]  = TAG_W'(s0);
    ds1[k*TAG_W +: TAG_W]  = TAG_W'(s1);
    dr0[k] = r0;
    dr1[k] = r1;
  endtask

  // compare against model, advance model over the coming edge
  task automatic tick();
    int  pk [2];
    bit  ev [2];
    bit  er;
    #1;
    er = (m_count() <= DEPTH - 2);
    chk(dec_ready_o == er, "R2", int'(dec_ready_o), int'(er));
    for (int f = 0; f < 2; f++) begin
      pk[f] = m_pick(f);
      ev[f] = (pk[f] >= 0) && free[f];
      chk(iss_valid_o[f] == ev[f], "R4", int'(iss_valid_o[f]), int'(ev[f]));
      if (ev[f] && iss_valid_o[f]) begin
        chk(dst_of(f) == m_dst[pk[f]], "R5", dst_of(f), m_dst[pk[f]]);
        chk(int'(iss_src0_o[f*TAG_W +: TAG_W]) == m_s0[pk[f]] &&
            int'(iss_src1_o[f*TAG_W +: TAG_W]) == m_s1[pk[f]], "R5",
            int'(iss_src0_o[f*TAG_W +: TAG_W]), m_s0[pk[f]]);
      end
    end
    for (int f = 0; f < 2; f++) if (ev[f]) m_v[pk[f]] = 0;
    if (cv)
      for (int i = 0; i < DEPTH; i++) if (m_v[i]) begin
        if (m_s0[i] == int'(ctag)) m_r0[i] = 1;
        if (m_s1[i] == int'(ctag)) m_r1[i] = 1;
      end
    if (er)
      for (int k = 0; k < 2; k++) if (dv[k]) begin
        int s = -1;
        for (int i = 0; i < DEPTH; i++) if (!m_v[i] && s < 0) s = i;
        if (s >= 0) begin
          m_v[s] = 1; m_fu[s] = int'(dfu[k]);
          m_dst[s] = int'(ddst[k*TAG_W +: TAG_W]);
          m_s0[s] = int'(ds0[k*TAG_W +: TAG_W]);
          m_s1[s] = int'(ds1[k*TAG_W +: TAG_W]);
          m_r0[s] = dr0[k] || (cv && ctag == ds0[k*TAG_W +: TAG_W]);
          m_r1[s] = dr1[k] || (cv && ctag == ds1[k*TAG_W +: TAG_W]);
          m_seq[s] = seq_n++;
        end
      end
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int dn = 0;
    void'($urandom(32'd4117));
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(dec_ready_o == 1'b1, "R1", int'(dec_ready_o), 1);
    chk(iss_valid_o == 2'b00, "R1", int'(iss_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10: six blocked pairs fill the buffer
    for (int p = 0; p < 6; p++) begin
      set_lane(0, 0, 2*p, 50, 0, 1, 1);
      set_lane(1, 0, 2*p+1, 50, 0, 1, 1);
      dv = 2'b11;
      #1 chk(dec_ready_o == 1'b1, "R10", int'(dec_ready_o), 1);
      tick();
    end
    idle();
    #1 chk(dec_ready_o == 1'b0, "R10", int'(dec_ready_o), 0);
    // R2: insert while full is dropped
    set_lane(0, 1, 60, 1, 1, 1, 1);
    dv = 2'b01;
    tick();
    idle();
    #1 chk(iss_valid_o[1] == 1'b0, "R2", int'(iss_valid_o[1]), 0);
    // R7: wake all, no issue in broadcast cycle
    cv = 1'b1; ctag = 6'd50;
    #1 chk(iss_valid_o[0] == 1'b0, "R7", int'(iss_valid_o[0]), 0);
    tick();
    idle();
    #1 chk(iss_valid_o[0] == 1'b1 && dst_of(0) == 0, "R7", dst_of(0), 0);
    repeat (14) tick();

    // R6: younger ready entry bypasses older waiting one
    set_lane(0, 0, 20, 40, 0, 2, 1); dv = 2'b01; tick();
    set_lane(0, 0, 21, 3, 1, 2, 1);  dv = 2'b01; tick();
    idle();
    #1 chk(iss_valid_o[0] && dst_of(0) == 21, "R6", dst_of(0), 21);
    tick();
    cv = 1'b1; ctag = 6'd40; tick();
    idle();
    #1 chk(iss_valid_o[0] && dst_of(0) == 20, "R6", dst_of(0), 20);
    tick();

    // R8: insert together with matching completion
    set_lane(0, 1, 22, 33, 0, 2, 1); dv = 2'b01; cv = 1'b1; ctag = 6'd33; tick();
    idle();
    #1 chk(iss_valid_o[1] && dst_of(1) == 22, "R8", dst_of(1), 22);
    tick();

    // R9: unit busy holds the entry, then issues once
    free = 2'b00;
    set_lane(0, 0, 23, 2, 1, 2, 1); dv = 2'b01; tick();
    idle();
    #1 chk(iss_valid_o[0] == 1'b0, "R9", int'(iss_valid_o[0]), 0);
    tick();
    free = 2'b11;
    #1 chk(iss_valid_o[0] && dst_of(0) == 23, "R9", dst_of(0), 23);
    tick();
    #1 chk(iss_valid_o[0] == 1'b0, "R9", int'(iss_valid_o[0]), 0);
    tick();

    // R3: pair order, lane 0 first
    set_lane(0, 0, 24, 2, 1, 2, 1);
    set_lane(1, 0, 25, 2, 1, 2, 1);
    dv = 2'b11; tick();
    idle();
    #1 chk(iss_valid_o[0] && dst_of(0) == 24, "R3", dst_of(0), 24);
    tick();
    #1 chk(iss_valid_o[0] && dst_of(0) == 25, "R3", dst_of(0), 25);
    tick();

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      for (int k = 0; k < 2; k++) begin
        set_lane(k, int'($urandom_range(1)), dn, int'($urandom_range(15)),
                 ($urandom_range(9) < 7), int'($urandom_range(15)), ($urandom_range(9) < 7));
        dn = (dn + 1) % 64;
      end
      dv   = 2'($urandom_range(3));
      cv   = ($urandom_range(9) < 4);
      ctag = TAG_W'($urandom_range(15));
      free = {($urandom_range(9) < 8), ($urandom_range(9) < 8)};
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule